// File: doc/BRIEF.md
# Parallel Port Word Buffer with Non-Blocking Mode

This block sits between a processor core (or a DMA engine using the same access port) and the shift logic of an external parallel port. It moves 32-bit words in both directions. On the transmit side, a word written by the core lands in a holding slot. It then moves by itself into a shift slot before the pin sequencer takes it out. On the receive side, words from the pin sequencer pass through an input slot into a holding slot, and the core reads them from there. Each direction therefore buffers two words. A two-bit fill code reports the fill level of the direction selected by a configuration pin.

A configuration bit chooses between two policies. In the blocking policy, an access that cannot complete raises a stall until it can: a write while no transmit slot frees up, or a read while the receive holding slot is empty. In the non-blocking policy there is never a stall. A read of an empty receive buffer returns the last word again, and a write to a full transmit buffer replaces the word in the holding slot.

A small sequencer drives the external address-latch strobe, with a selectable active level, and a bus-busy flag. A one-bit flag shows that the previous cycle carried an accepted DMA-tagged access.

Top module: `ppx_databuf`

## Requirements
- R1: While reset is held, and after it is released, stall is 0, the fill code is 00, busy is 0, the DMA flag is 0, the transmit shift slot is empty, receive ready is 1, and the latch strobe sits at its inactive level.
- R2: The fill code is 00 for zero buffered words, 01 for one and 11 for two. The direction is transmit when `cfg_stat_tx_i` is 1 and receive when it is 0. The code 10 never appears.
- R3: With `cfg_nohang_i`=0, a write while the transmit holding slot cannot free up (holding and shift slots both full and no drain in that cycle) raises stall in the same cycle, and the word is not taken.
- R4: With `cfg_nohang_i`=0, a read while the receive holding slot is empty raises stall in the same cycle, and nothing is consumed.
- R5: With `cfg_nohang_i`=1, stall is never raised. `rd_data_o` always shows the receive holding slot, so a read of an empty buffer returns the previously held word again.
- R6: With `cfg_nohang_i`=1, a write to a full transmit buffer replaces the word in the holding slot and leaves the shift slot word unchanged.
- R7: A write and a drain (`tx_take_i` with the shift slot full) in the same cycle are both honoured with no stall and no overwrite, and the words leave in write order.
- R8: The holding word moves to the shift slot on the edge where the shift slot is empty or being drained. Transmit words leave in the order they were written.
- R9: `rx_ready_o` is 1 while fewer than two receive words are held. A push while it is 0 is ignored. Received words are read back in arrival order.
- R10: `ale_o` equals the internal latch-active state when `cfg_ale_low_i`=0, and its inverse when `cfg_ale_low_i`=1.
- R11: From idle, `ext_start_i` makes the latch active and busy high for exactly one cycle. After that, busy clears if `ext_latch_only_i` was set with the start. Otherwise busy holds until the cycle after `ext_done_i`. A start while busy is ignored.
- R12: `dma_act_o` is 1 in the cycle after an unstalled access with `acc_dma_i`=1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_nohang_i | input | 1 | 1 selects the non-blocking policy |
| cfg_ale_low_i | input | 1 | 1 makes the latch strobe active low |
| cfg_stat_tx_i | input | 1 | Fill code direction: 1 transmit, 0 receive |
| acc_dma_i | input | 1 | Tags the current access as coming from DMA |
| wr_en_i | input | 1 | Write request into the transmit holding slot |
| wr_data_i | input | 32 | Write word |
| rd_en_i | input | 1 | Read request from the receive holding slot |
| rd_data_o | output | 32 | Receive holding slot word |
| stall_o | output | 1 | Access cannot complete this cycle |
| fill_stat_o | output | 2 | Fill code of the selected direction |
| dma_act_o | output | 1 | Accepted DMA access in the previous cycle |
| tx_take_i | input | 1 | Pin sequencer takes the shift slot word |
| tx_sh_valid_o | output | 1 | Shift slot holds a word |
| tx_sh_data_o | output | 32 | Shift slot word |
| rx_push_i | input | 1 | Pin sequencer delivers a received word |
| rx_push_data_i | input | 32 | Received word |
| rx_ready_o | output | 1 | Receive side can take a word |
| ext_start_i | input | 1 | Begin an external access |
| ext_latch_only_i | input | 1 | Access consists of the latch cycle only |
| ext_done_i | input | 1 | Read or write cycle completed |
| ale_o | output | 1 | Address-latch strobe at the pin level |
| bus_busy_o | output | 1 | External access in progress |

## Verification
A core write and a shift-slot drain can land in the same cycle, and their order decides whether a full buffer stalls, overwrites or accepts. The bench provokes this collision in a long sweep that sets write, drain, read, push, DMA tag, fill-code direction and the policy bit in every combination over many buffer states. A reference queue in the bench, built from the requirements, predicts the stall, fill code and words for each cycle. Directed sequences then fill the transmit side and hit it with a write plus drain under each policy. They are judged by the order in which the written words reach the shift slot.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_PART  = 2'b01,
    FILL_FULL  = 2'b11
  } fill_e;

  typedef enum logic [1:0] {
    EXT_IDLE  = 2'b00,
    EXT_LATCH = 2'b01,
    EXT_DATA  = 2'b10
  } ext_state_e;

  // fill code from the occupancy of a two-slot path
  function automatic fill_e fill_code(input logic slot_a, input logic slot_b);
    fill_e code;
    unique case ({slot_a, slot_b})
      2'b00:   code = FILL_EMPTY;
      2'b11:   code = FILL_FULL;
      default: code = FILL_PART;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/ppx_tx_slot.sv
module ppx_tx_slot
  import ppx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_go_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          hold_free_o,
  output logic [1:0]    fill_o,
  output logic          sh_valid_o,
  output logic [DW-1:0] sh_data_o
);

  logic          hold_v_q, hold_v_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          sh_v_q, sh_v_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          drain, move;
  fill_e         fill;

  assign drain       = take_i & sh_v_q;
  assign move        = hold_v_q & (~sh_v_q | drain);
  assign hold_free_o = ~hold_v_q | move;

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    sh_v_d   = sh_v_q;
    sh_d     = sh_q;
    if (move) begin
      sh_v_d = 1'b1;
      sh_d   = hold_q;
    end else if (drain) begin
      sh_v_d = 1'b0;
    end
    if (wr_go_i) begin
      hold_v_d = 1'b1;
      hold_d   = wr_data_i;
    end else if (move) begin
      hold_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      sh_v_q   <= 1'b0;
      sh_q     <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      sh_v_q   <= sh_v_d;
      if (wr_go_i) hold_q <= hold_d;
      if (move)    sh_q   <= sh_d;
    end
  end

  assign fill       = fill_code(hold_v_q, sh_v_q);
  assign fill_o     = fill;
  assign sh_valid_o = sh_v_q;
  assign sh_data_o  = sh_q;

  // an occupied shift slot that is not taken keeps its word (overwrite hits only the holding slot)
  p_shift_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_v_q && !take_i) |=> (sh_v_q && $stable(sh_q)));

  // an empty shift slot is refilled from a waiting holding word on the next edge
  p_autoload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_q && !sh_v_q) |=> sh_v_q);

endmodule

// File: rtl/ppx_rx_slot.sv
module ppx_rx_slot
  import ppx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_go_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  output logic          ready_o,
  output logic          hold_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [1:0]    fill_o
);

  logic          hold_v_q, hold_v_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          in_v_q, in_v_d;
  logic [DW-1:0] in_q, in_d;
  logic          push_ok, pop, advance;
  fill_e         fill;

  assign ready_o = ~(hold_v_q & in_v_q);
  assign push_ok = push_i & ready_o;
  assign pop     = rd_go_i & hold_v_q;
  assign advance = in_v_q & (~hold_v_q | pop);

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    in_v_d   = in_v_q;
    in_d     = in_q;
    if (advance) begin
      hold_v_d = 1'b1;
      hold_d   = in_q;
    end else if (pop) begin
      hold_v_d = 1'b0;
    end
    if (push_ok) begin
      in_v_d = 1'b1;
      in_d   = push_data_i;
    end else if (advance) begin
      in_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      in_v_q   <= 1'b0;
      in_q     <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      in_v_q   <= in_v_d;
      if (advance) hold_q <= hold_d;
      if (push_ok) in_q   <= in_d;
    end
  end

  assign fill         = fill_code(hold_v_q, in_v_q);
  assign fill_o       = fill;
  assign hold_valid_o = hold_v_q;
  assign rd_data_o    = hold_q;

  // with nothing buffered, the last word stays readable
  p_stale_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_v_q && !in_v_q) |=> $stable(hold_q));

  // a push refused while full leaves the input slot word alone
  p_refused_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && hold_v_q && in_v_q && !rd_go_i) |=> $stable(in_q));

endmodule

// File: rtl/ppx_strobe_seq.sv
module ppx_strobe_seq
  import ppx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_ale_low_i,
  input  logic start_i,
  input  logic latch_only_i,
  input  logic done_i,
  output logic ale_o,
  output logic busy_o
);

  ext_state_e state_q, state_d;
  logic       only_q, only_d;
  logic       latch_act;

  always_comb begin
    state_d = state_q;
    only_d  = only_q;
    unique case (state_q)
      EXT_IDLE: begin
        if (start_i) begin
          state_d = EXT_LATCH;
          only_d  = latch_only_i;
        end
      end
      EXT_LATCH: state_d = only_q ? EXT_IDLE : EXT_DATA;
      EXT_DATA:  if (done_i) state_d = EXT_IDLE;
      default:   state_d = EXT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EXT_IDLE;
      only_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      only_q  <= only_d;
    end
  end

  assign latch_act = (state_q == EXT_LATCH);
  assign busy_o    = (state_q != EXT_IDLE);
  assign ale_o     = latch_act ^ cfg_ale_low_i;

  p_latch_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_act |=> !latch_act);

  p_start_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && latch_act));

  p_pin_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> (ale_o == cfg_ale_low_i));

endmodule

// File: rtl/ppx_databuf.sv
module ppx_databuf
  import ppx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_nohang_i,
  input  logic              cfg_ale_low_i,
  input  logic              cfg_stat_tx_i,
  input  logic              acc_dma_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stall_o,
  output logic [1:0]        fill_stat_o,
  output logic              dma_act_o,
  input  logic              tx_take_i,
  output logic              tx_sh_valid_o,
  output logic [DATA_W-1:0] tx_sh_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_push_data_i,
  output logic              rx_ready_o,
  input  logic              ext_start_i,
  input  logic              ext_latch_only_i,
  input  logic              ext_done_i,
  output logic              ale_o,
  output logic              bus_busy_o
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic       rst_sync_n;
  logic       tx_hold_free, rx_hold_v;
  logic [1:0] tx_fill, rx_fill;
  logic       stall_wr, stall_rd, stall;
  logic       wr_go, rd_go;
  logic       dma_q, dma_d;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_MSB:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_MSB-1:0], 1'b1};
      end
      assign rst_sync_n = sync_q[SYNC_MSB];
    end
  endgenerate

  // hazard detection: a blocked access freezes the whole port for the cycle
  assign stall_wr = wr_en_i & ~cfg_nohang_i & ~tx_hold_free;
  assign stall_rd = rd_en_i & ~cfg_nohang_i & ~rx_hold_v;
  assign stall    = stall_wr | stall_rd;
  assign wr_go    = wr_en_i & ~stall;
  assign rd_go    = rd_en_i & ~stall;
  assign stall_o  = stall;

  ppx_tx_slot #(.DW(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .wr_go_i     (wr_go),
    .wr_data_i   (wr_data_i),
    .take_i      (tx_take_i),
    .hold_free_o (tx_hold_free),
    .fill_o      (tx_fill),
    .sh_valid_o  (tx_sh_valid_o),
    .sh_data_o   (tx_sh_data_o)
  );

  ppx_rx_slot #(.DW(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .rd_go_i      (rd_go),
    .push_i       (rx_push_i),
    .push_data_i  (rx_push_data_i),
    .ready_o      (rx_ready_o),
    .hold_valid_o (rx_hold_v),
    .rd_data_o    (rd_data_o),
    .fill_o       (rx_fill)
  );

  ppx_strobe_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cfg_ale_low_i (cfg_ale_low_i),
    .start_i       (ext_start_i),
    .latch_only_i  (ext_latch_only_i),
    .done_i        (ext_done_i),
    .ale_o         (ale_o),
    .busy_o        (bus_busy_o)
  );

  assign fill_stat_o = cfg_stat_tx_i ? tx_fill : rx_fill;

  always_comb begin
    dma_d = (wr_go | rd_go) & acc_dma_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) dma_q <= 1'b0;
    else             dma_q <= dma_d;
  end

  assign dma_act_o = dma_q;

  p_fill_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fill_stat_o != 2'b10);

  p_full_write_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && !cfg_nohang_i && tx_fill == FILL_FULL && !tx_take_i) |-> stall_o);

  p_empty_read_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rd_en_i && !cfg_nohang_i && rx_fill == FILL_EMPTY) |-> stall_o);

  p_nohang_free_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cfg_nohang_i |-> !stall_o);

  p_drain_write_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && !rd_en_i && tx_take_i && tx_sh_valid_o) |-> !stall_o);

  p_dma_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && acc_dma_i && !stall_o) |=> dma_act_o);

endmodule

// File: tb/ppx_databuf_bench.sv
`timescale 1ns/1ps
module ppx_databuf_bench;

  logic        clk;
  logic        rst_n;
  logic        nohang, ale_low, stat_tx, dma_tag;
  logic        wr_en, rd_en, take, push;
  logic [31:0] wr_data, push_data;
  logic        ext_start, ext_only, ext_done;
  logic [31:0] rd_data, sh_data;
  logic        stall, dma_act, sh_valid, rx_ready, ale, busy;
  logic [1:0]  fill;

  int n_chk = 0;
  int n_bad = 0;

  // reference queue state
  logic        m_th_v, m_ts_v, m_rh_v, m_ri_v, m_dma;
  logic [31:0] m_th, m_ts, m_rh, m_ri;

  ppx_databuf u_ppx_databuf (
    .clk_i(clk), .rst_ni(rst_n), .cfg_nohang_i(nohang), .cfg_ale_low_i(ale_low),
    .cfg_stat_tx_i(stat_tx), .acc_dma_i(dma_tag), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .stall_o(stall), .fill_stat_o(fill),
    .dma_act_o(dma_act), .tx_take_i(take), .tx_sh_valid_o(sh_valid), .tx_sh_data_o(sh_data),
    .rx_push_i(push), .rx_push_data_i(push_data), .rx_ready_o(rx_ready),
    .ext_start_i(ext_start), .ext_latch_only_i(ext_only), .ext_done_i(ext_done),
    .ale_o(ale), .bus_busy_o(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic logic [1:0] code_of(input int cnt);
    return (cnt == 0) ? 2'b00 : (cnt == 1) ? 2'b01 : 2'b11;
  endfunction

  // one cycle of the buffer: drive, compare against the reference, advance the reference
  task automatic step(input logic wr, input logic [31:0] wd, input logic rd, input logic tk,
                      input logic ps, input logic [31:0] pd, input logic dm,
                      input logic st, input logic nh);
    logic e_free, e_stall, wg, rg, drain, mv, push_ok, pop, adv;
    logic n_th_v, n_ts_v, n_rh_v, n_ri_v;
    logic [31:0] n_th, n_ts, n_rh, n_ri;
    int cnt;
    wr_en = wr; wr_data = wd; rd_en = rd; take = tk; push = ps; push_data = pd;
    dma_tag = dm; stat_tx = st; nohang = nh;
    #1;
    drain   = tk && m_ts_v;
    mv      = m_th_v && (!m_ts_v || drain);
    e_free  = !m_th_v || mv;
    e_stall = !nh && ((wr && !e_free) || (rd && !m_rh_v));
    chk("R3 R4 R5 stall", {31'd0, stall}, {31'd0, e_stall});
    cnt = st ? (int'(m_th_v) + int'(m_ts_v)) : (int'(m_rh_v) + int'(m_ri_v));
    chk("R2 fill code", {30'd0, fill}, {30'd0, code_of(cnt)});
    chk("R8 shift valid", {31'd0, sh_valid}, {31'd0, m_ts_v});
    if (m_ts_v) chk("R8 shift word", sh_data, m_ts);
    chk("R5 R9 read word", rd_data, m_rh);
    chk("R9 rx ready", {31'd0, rx_ready}, {31'd0, !(m_rh_v && m_ri_v)});
    chk("R12 dma flag", {31'd0, dma_act}, {31'd0, m_dma});
    wg = wr && !e_stall;
    rg = rd && !e_stall;
    n_ts_v = mv ? 1'b1 : (drain ? 1'b0 : m_ts_v);
    n_ts   = mv ? m_th : m_ts;
    n_th_v = wg ? 1'b1 : (mv ? 1'b0 : m_th_v);
    n_th   = wg ? wd : m_th;
    push_ok = ps && !(m_rh_v && m_ri_v);
    pop     = rg && m_rh_v;
    adv     = m_ri_v && (!m_rh_v || pop);
    n_rh_v = adv ? 1'b1 : (pop ? 1'b0 : m_rh_v);
    n_rh   = adv ? m_ri : m_rh;
    n_ri_v = push_ok ? 1'b1 : (adv ? 1'b0 : m_ri_v);
    n_ri   = push_ok ? pd : m_ri;
    @(posedge clk);
    m_th_v = n_th_v; m_th = n_th; m_ts_v = n_ts_v; m_ts = n_ts;
    m_rh_v = n_rh_v; m_rh = n_rh; m_ri_v = n_ri_v; m_ri = n_ri;
    m_dma  = (wg || rg) && dm;
    @(negedge clk);
  endtask

  task automatic drain_all();
    for (int k = 0; k < 5; k++) step(1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 32'd0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nohang = 0; ale_low = 0; stat_tx = 0; dma_tag = 0;
    wr_en = 0; rd_en = 0; take = 0; push = 0; wr_data = 0; push_data = 0;
    ext_start = 0; ext_only = 0; ext_done = 0;
    m_th_v = 0; m_ts_v = 0; m_rh_v = 0; m_ri_v = 0; m_dma = 0;
    m_th = 0; m_ts = 0; m_rh = 0; m_ri = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: values while reset is held
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 fill", {30'd0, fill}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 dma", {31'd0, dma_act}, 32'd0);
    chk("R1 strobe", {31'd0, ale}, 32'd0);
    chk("R1 shift valid", {31'd0, sh_valid}, 32'd0);
    chk("R1 rx ready", {31'd0, rx_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // near-exhaustive sweep of the seven controls across many buffer states
    for (int n = 0; n < 4096; n++) begin
      logic [5:0] b;
      b = n[5:0] ^ {n[8:6], n[11:9]};
      step(b[0], 32'hA000_0000 + n, b[1], b[2], b[3], 32'h5000_0000 + n, b[4], b[5], n[8]);
    end
    drain_all();

    // R6: overwrite of the holding slot under the non-blocking policy
    step(1'b1, 32'h0000_00A1, 0, 0, 0, 0, 0, 1, 1);
    step(1'b0, 32'h0, 0, 0, 0, 0, 0, 1, 1);
    step(1'b1, 32'h0000_00B2, 0, 0, 0, 0, 0, 1, 1);
    step(1'b1, 32'h0000_00C3, 0, 0, 0, 0, 0, 1, 1);
    #1 chk("R6 shift word kept", sh_data, 32'h0000_00A1);
    step(1'b0, 32'h0, 0, 1, 0, 0, 0, 1, 1);
    #1 chk("R6 overwritten word follows", sh_data, 32'h0000_00C3);
    drain_all();

    // R7: write and drain together on a full buffer, blocking policy
    step(1'b1, 32'h0000_00D4, 0, 0, 0, 0, 0, 1, 0);
    step(1'b0, 32'h0, 0, 0, 0, 0, 0, 1, 0);
    step(1'b1, 32'h0000_00E5, 0, 0, 0, 0, 0, 1, 0);
    wr_en = 1; wr_data = 32'h0000_00F6; take = 1; rd_en = 0; push = 0; nohang = 0;
    #1 chk("R7 no stall on write with drain", {31'd0, stall}, 32'd0);
    step(1'b1, 32'h0000_00F6, 0, 1, 0, 0, 0, 1, 0);
    #1 chk("R7 second word next", sh_data, 32'h0000_00E5);
    step(1'b0, 32'h0, 0, 1, 0, 0, 0, 1, 0);
    #1 chk("R7 third word kept", sh_data, 32'h0000_00F6);
    drain_all();
    wr_en = 0; rd_en = 0; take = 0; push = 0;

    // R10 / R11: strobe and busy, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      ale_low = pol[0];
      #1 chk("R10 idle level", {31'd0, ale}, {31'd0, pol[0]});
      ext_start = 1; ext_only = 0;
      tick();
      ext_start = 0;
      chk("R10 latch active level", {31'd0, ale}, {31'd0, ~pol[0]});
      chk("R11 busy in latch", {31'd0, busy}, 32'd1);
      ext_start = 1;
      tick();
      ext_start = 0;
      chk("R11 latch one cycle", {31'd0, ale}, {31'd0, pol[0]});
      chk("R11 busy in data", {31'd0, busy}, 32'd1);
      tick();
      chk("R11 start while busy ignored", {31'd0, ale}, {31'd0, pol[0]});
      chk("R11 busy holds", {31'd0, busy}, 32'd1);
      ext_done = 1;
      tick();
      ext_done = 0;
      chk("R11 busy clears after done", {31'd0, busy}, 32'd0);
      ext_start = 1; ext_only = 1;
      tick();
      ext_start = 0; ext_only = 0;
      chk("R11 latch-only busy", {31'd0, busy}, 32'd1);
      tick();
      chk("R11 latch-only ends", {31'd0, busy}, 32'd0);
      chk("R10 back to idle level", {31'd0, ale}, {31'd0, pol[0]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule